// File: doc/BRIEF.md
# Vector Length State Register

This block holds the loop-control state of a vector-capable core in a single 32-bit control register: the maximum vector length, the active vector length, the sub-vector group size and three running loop offsets (source element, destination element and sub-vector destination element). The loop sequencer reads the decoded field values straight from the outputs. Software reaches the same state through four register views. Three views cover the maximum length, the length and the group size, and each reads as a true count. The fourth is a packed view that holds every field as a compact code, so that a whole vector context can be saved or restored with one access.

Writes come in two kinds. A register-sourced write carries a full data word and is range-checked. An illegal value raises a one-cycle exception flag and changes nothing. An immediate write carries a 5-bit immediate that is biased by one, so every code is legal. Lengths are held as count minus one. Every write clamps the dependent fields so that the vector length never exceeds the maximum and no offset points past its loop bound. On trap entry or return, the active state is exchanged with a shadow copy kept for the privilege level named by the trap, so a handler at that level gets its own vector context. The interrupted context comes back untouched when the handler returns.

Top module: `vec_state_csr`

## Requirements
- R1: After reset every field code is zero: a packed read returns 0, and the outputs show maximum length 1, length 1, group size 1 and all offsets 0.
- R2: The packed view (address 0x804) reads {4'b0, dsv[1:0], grp[1:0], dst[5:0], src[5:0], len_code[5:0], max_code[5:0]}, with bit 0 the least significant bit. The maximum and length codes are the value minus one, and the group code is the group size minus one. The maximum-length view (0x801) and the length view (0x802) read the true counts.
- R3: A register-sourced write (kind 01) of 0, or of a value above XLEN, to the maximum-length or length view asserts csr_illegal in that cycle and leaves all state unchanged.
- R4: An immediate write (kind 10) to the maximum-length or length view uses only wdata[4:0] and stores that immediate plus one.
- R5: A write to the maximum-length view returns the old maximum on csr_rdata. A write to the length view returns the new length, after clamping.
- R6: A length write above the current maximum is clamped to the maximum. A maximum write below the current length pulls the length down to the new maximum and clamps both element offsets to the new length minus one.
- R7: The group-size view (0x803) reads the true size 1 to 4, held as codes 00 to 11. A write of 0 or above 4 is flagged illegal and changes nothing. A legal write resets the sub-vector offset to 0 and returns the old size.
- R8: A packed write truncates the maximum to XLEN, clamps the length to the maximum, clamps both element offsets to length minus one, and clamps the sub-vector offset to group size minus one. It never raises the exception.
- R9: Any legal write to the length view resets the source and destination offsets to zero.
- R10: A trap_enter or trap_exit pulse exchanges the active state with the shadow copy of the level on trap_priv; shadows reset to zero. A register access in the same cycle as a trap does not write and does not flag.
- R11: Kind 00 and kind 11 are reads with no effect. An access to any other address reads 0 and changes nothing.
- R12: Bits 31:28 of the packed view always read zero, and values written to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register view address |
| csr_kind | input | 2 | 00 read, 01 register write, 10 immediate write, 11 read |
| csr_wdata | input | XLEN | Write data; immediate writes use bits 4:0 |
| trap_enter | input | 1 | Trap entry strobe |
| trap_exit | input | 1 | Trap return strobe |
| trap_priv | input | PRIV_W | Privilege level whose shadow is exchanged |
| csr_rdata | output | XLEN | Value returned by the access |
| csr_illegal | output | 1 | Illegal write value in this cycle |
| mvl_len | output | 7 | Maximum vector length, true count |
| vl_len | output | 7 | Vector length, true count |
| subvl_len | output | 3 | Sub-vector group size, 1 to 4 |
| src_offs | output | 6 | Source element offset |
| dst_offs | output | 6 | Destination element offset |
| dsv_offs | output | 2 | Sub-vector destination offset |

## Verification
The bench builds the block with XLEN of 32 and three privilege levels. With XLEN at 32, packed codes of 32 to 63 fall outside the legal range, so the truncation of the maximum to XLEN is exercised. The rejection of 33 and the acceptance of exactly 32 sit on the upper length boundary. Three shadow slots let the bench show that a swap through one level leaves another level's reset-time copy untouched.

// File: rtl/vsc_pkg.sv
package vsc_pkg;

   localparam int FLD_W   = 6;
   localparam int SUB_W   = 2;
   localparam int STATE_W = 4 * FLD_W + 2 * SUB_W;

   // Field order is the packed-view layout, most significant first.
   typedef struct packed {
      logic [SUB_W-1:0] dsvoffs;
      logic [SUB_W-1:0] subvl_m1;
      logic [FLD_W-1:0] destoffs;
      logic [FLD_W-1:0] srcoffs;
      logic [FLD_W-1:0] vl_m1;
      logic [FLD_W-1:0] mvl_m1;
   } vstate_t;

   typedef enum logic [1:0] {
      WK_READ = 2'b00,
      WK_REG  = 2'b01,
      WK_IMM  = 2'b10,
      WK_RSV  = 2'b11
   } wr_kind_e;

   function automatic logic [FLD_W-1:0] fld_min(input logic [FLD_W-1:0] a,
                                                input logic [FLD_W-1:0] b);
      return (a < b) ? a : b;
   endfunction

   function automatic logic [SUB_W-1:0] sub_min(input logic [SUB_W-1:0] a,
                                                input logic [SUB_W-1:0] b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/vsc_write_decode.sv
module vsc_write_decode
   import vsc_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter logic [11:0] ADDR_MVL   = 12'h801,
   parameter logic [11:0] ADDR_VL    = 12'h802,
   parameter logic [11:0] ADDR_SUBVL = 12'h803,
   parameter logic [11:0] ADDR_STATE = 12'h804
) (
   input  vstate_t           cur,
   input  logic [11:0]       addr,
   input  logic [1:0]        kind,
   input  logic [XLEN-1:0]   wdata,
   output vstate_t           nxt,
   output logic              wr_en,
   output logic              illegal,
   output logic [XLEN-1:0]   rdata
);

   localparam int               LEN_W     = FLD_W + 1;
   localparam logic [XLEN-1:0]  XLEN_V    = XLEN'(XLEN);
   localparam logic [XLEN-1:0]  SUB_MAX_V = XLEN'(1 << SUB_W);
   localparam logic [FLD_W-1:0] MAX_CODE  = FLD_W'(XLEN - 1);

   wr_kind_e          k;
   logic              is_wr;
   logic [XLEN-1:0]   src_v;
   logic [LEN_W-1:0]  len_v;
   logic              len_bad;
   logic              sub_bad;
   logic [FLD_W-1:0]  len_code;
   logic [SUB_W-1:0]  sub_code;
   vstate_t           req;

   assign k = wr_kind_e'(kind);

   // Operand shaping shared by every view.
   always_comb begin
      is_wr   = (k == WK_REG) || (k == WK_IMM);
      src_v   = (k == WK_IMM) ? XLEN'(wdata[4:0]) : wdata;
      if (k == WK_IMM) len_v = LEN_W'(wdata[4:0]) + LEN_W'(1);
      else             len_v = wdata[LEN_W-1:0];
      len_bad  = (k == WK_REG) && ((wdata == '0) || (wdata > XLEN_V));
      len_code = FLD_W'(len_v - LEN_W'(1));
      sub_bad  = (src_v == '0) || (src_v > SUB_MAX_V);
      sub_code = SUB_W'(src_v - XLEN'(1));
      req      = vstate_t'(src_v[STATE_W-1:0]);
   end

   always_comb begin
      nxt     = cur;
      wr_en   = 1'b0;
      illegal = 1'b0;
      rdata   = '0;
      if (addr == ADDR_MVL) begin
         rdata = XLEN'(cur.mvl_m1) + XLEN'(1);
         if (is_wr) begin
            if (len_bad) illegal = 1'b1;
            else begin
               wr_en        = 1'b1;
               nxt.mvl_m1   = len_code;
               nxt.vl_m1    = fld_min(cur.vl_m1, len_code);
               nxt.srcoffs  = fld_min(cur.srcoffs, nxt.vl_m1);
               nxt.destoffs = fld_min(cur.destoffs, nxt.vl_m1);
            end
         end
      end else if (addr == ADDR_VL) begin
         rdata = XLEN'(cur.vl_m1) + XLEN'(1);
         if (is_wr) begin
            if (len_bad) illegal = 1'b1;
            else begin
               wr_en        = 1'b1;
               nxt.vl_m1    = fld_min(len_code, cur.mvl_m1);
               nxt.srcoffs  = '0;
               nxt.destoffs = '0;
               rdata        = XLEN'(nxt.vl_m1) + XLEN'(1);
            end
         end
      end else if (addr == ADDR_SUBVL) begin
         rdata = XLEN'(cur.subvl_m1) + XLEN'(1);
         if (is_wr) begin
            if (sub_bad) illegal = 1'b1;
            else begin
               wr_en        = 1'b1;
               nxt.subvl_m1 = sub_code;
               nxt.dsvoffs  = '0;
            end
         end
      end else if (addr == ADDR_STATE) begin
         rdata = XLEN'(cur);
         if (is_wr) begin
            wr_en        = 1'b1;
            nxt.mvl_m1   = fld_min(req.mvl_m1, MAX_CODE);
            nxt.vl_m1    = fld_min(req.vl_m1, nxt.mvl_m1);
            nxt.srcoffs  = fld_min(req.srcoffs, nxt.vl_m1);
            nxt.destoffs = fld_min(req.destoffs, nxt.vl_m1);
            nxt.subvl_m1 = req.subvl_m1;
            nxt.dsvoffs  = sub_min(req.dsvoffs, req.subvl_m1);
         end
      end
   end

endmodule

// File: rtl/vsc_state_bank.sv
module vsc_state_bank
   import vsc_pkg::*;
#(
   parameter int NUM_PRIV = 3,
   parameter int PRIV_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  vstate_t           wr_state,
   input  logic              swap_req,
   input  logic [PRIV_W-1:0] swap_priv,
   output vstate_t           active
);

   vstate_t active_q;
   vstate_t shadow_q [NUM_PRIV];
   vstate_t shadow_sel;
   logic    swap_ok;

   assign swap_ok = swap_req && (32'(swap_priv) < NUM_PRIV);
   assign active  = active_q;

   always_comb begin
      shadow_sel = '0;
      for (int i = 0; i < NUM_PRIV; i++) begin
         if (32'(swap_priv) == i) shadow_sel = shadow_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       active_q <= '0;
      else if (swap_ok) active_q <= shadow_sel;
      else if (wr_en)   active_q <= wr_state;
   end

   generate
      for (genvar g = 0; g < NUM_PRIV; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               shadow_q[g] <= '0;
            else if (swap_ok && (32'(swap_priv) == g))
               shadow_q[g] <= active_q;
         end
      end
   endgenerate

   // R10: the active copy takes the selected shadow on a swap.
   p_swap_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
      swap_ok |=> (active_q == $past(shadow_sel)));

   // R10: the outgoing active copy lands in the selected shadow.
   p_swap_saves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (swap_ok && !$past(swap_ok)) |=> (shadow_sel == $past(active_q)) || (swap_priv != $past(swap_priv)));

endmodule

// File: rtl/vec_state_csr.sv
module vec_state_csr
   import vsc_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          NUM_PRIV   = 3,
   parameter logic [11:0] ADDR_MVL   = 12'h801,
   parameter logic [11:0] ADDR_VL    = 12'h802,
   parameter logic [11:0] ADDR_SUBVL = 12'h803,
   parameter logic [11:0] ADDR_STATE = 12'h804,
   localparam int         PRIV_W     = (NUM_PRIV > 1) ? $clog2(NUM_PRIV) : 1,
   localparam int         LEN_W      = FLD_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       csr_addr,
   input  logic [1:0]        csr_kind,
   input  logic [XLEN-1:0]   csr_wdata,
   input  logic              trap_enter,
   input  logic              trap_exit,
   input  logic [PRIV_W-1:0] trap_priv,
   output logic [XLEN-1:0]   csr_rdata,
   output logic              csr_illegal,
   output logic [LEN_W-1:0]  mvl_len,
   output logic [LEN_W-1:0]  vl_len,
   output logic [SUB_W:0]    subvl_len,
   output logic [FLD_W-1:0]  src_offs,
   output logic [FLD_W-1:0]  dst_offs,
   output logic [SUB_W-1:0]  dsv_offs
);

   if (XLEN < 32 || XLEN > (1 << FLD_W)) begin : g_bad_xlen
      $error("XLEN must hold the packed view and fit the length codes");
   end
   if (NUM_PRIV < 1) begin : g_bad_priv
      $error("NUM_PRIV must be at least one");
   end

   vstate_t st;
   vstate_t st_nxt;
   logic    dec_wr;
   logic    dec_illegal;
   logic    trap_any;

   assign trap_any = trap_enter || trap_exit;

   vsc_write_decode #(
      .XLEN       (XLEN),
      .ADDR_MVL   (ADDR_MVL),
      .ADDR_VL    (ADDR_VL),
      .ADDR_SUBVL (ADDR_SUBVL),
      .ADDR_STATE (ADDR_STATE)
   ) u_dec (
      .cur     (st),
      .addr    (csr_addr),
      .kind    (csr_kind),
      .wdata   (csr_wdata),
      .nxt     (st_nxt),
      .wr_en   (dec_wr),
      .illegal (dec_illegal),
      .rdata   (csr_rdata)
   );

   vsc_state_bank #(
      .NUM_PRIV (NUM_PRIV),
      .PRIV_W   (PRIV_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (dec_wr && !trap_any),
      .wr_state  (st_nxt),
      .swap_req  (trap_any),
      .swap_priv (trap_priv),
      .active    (st)
   );

   assign csr_illegal = dec_illegal && !trap_any;
   assign mvl_len     = LEN_W'(st.mvl_m1) + LEN_W'(1);
   assign vl_len      = LEN_W'(st.vl_m1) + LEN_W'(1);
   assign subvl_len   = (SUB_W + 1)'(st.subvl_m1) + (SUB_W + 1)'(1);
   assign src_offs    = st.srcoffs;
   assign dst_offs    = st.destoffs;
   assign dsv_offs    = st.dsvoffs;

   // R3, R7: a rejected value leaves the whole state as it was.
   p_bad_write_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |=> $stable(st));

   // R9: a legal length write clears both element offsets.
   p_vl_write_zeroes_offs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_any && (csr_addr == ADDR_VL) && !csr_illegal &&
       ((csr_kind == 2'b01) || (csr_kind == 2'b10)))
      |=> (src_offs == '0) && (dst_offs == '0));

   // R6: the length never exceeds the maximum.
   p_vl_le_mvl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vl_len <= mvl_len);

   // R8: element offsets stay below the length.
   p_offs_below_vl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (LEN_W'(src_offs) < vl_len) && (LEN_W'(dst_offs) < vl_len));

   // R8: the sub-vector offset stays below the group size.
   p_dsv_below_subvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (SUB_W + 1)'(dsv_offs) < subvl_len);

   // R12: reserved bits of the packed view read zero.
   p_rsv_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == ADDR_STATE) |-> (csr_rdata[XLEN-1:STATE_W] == '0));

   // R11: a plain read never changes the state.
   p_read_no_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_any && ((csr_kind == 2'b00) || (csr_kind == 2'b11))) |=> $stable(st));

endmodule

// File: tb/vec_state_csr_tb.sv
module vec_state_csr_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] A_MVL = 12'h801;
   localparam logic [11:0] A_VL  = 12'h802;
   localparam logic [11:0] A_SUB = 12'h803;
   localparam logic [11:0] A_ST  = 12'h804;
   localparam logic [1:0]  K_RD  = 2'b00;
   localparam logic [1:0]  K_REG = 2'b01;
   localparam logic [1:0]  K_IMM = 2'b10;
   localparam logic [1:0]  K_RSV = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] csr_addr;
   logic [1:0]  csr_kind;
   logic [31:0] csr_wdata;
   logic        trap_enter;
   logic        trap_exit;
   logic [1:0]  trap_priv;
   logic [31:0] csr_rdata;
   logic        csr_illegal;
   logic [6:0]  mvl_len;
   logic [6:0]  vl_len;
   logic [2:0]  subvl_len;
   logic [5:0]  src_offs;
   logic [5:0]  dst_offs;
   logic [1:0]  dsv_offs;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vec_state_csr u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .csr_addr    (csr_addr),
      .csr_kind    (csr_kind),
      .csr_wdata   (csr_wdata),
      .trap_enter  (trap_enter),
      .trap_exit   (trap_exit),
      .trap_priv   (trap_priv),
      .csr_rdata   (csr_rdata),
      .csr_illegal (csr_illegal),
      .mvl_len     (mvl_len),
      .vl_len      (vl_len),
      .subvl_len   (subvl_len),
      .src_offs    (src_offs),
      .dst_offs    (dst_offs),
      .dsv_offs    (dsv_offs)
   );

   function automatic logic [31:0] pk(input int mc, input int vc, input int sr,
                                      input int ds, input int sb, input int dv);
      return {4'b0, 2'(dv), 2'(sb), 6'(ds), 6'(sr), 6'(vc), 6'(mc)};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic acc(input logic [11:0] a, input logic [1:0] k, input logic [31:0] d,
                      output logic [31:0] rd, output logic ill);
      @(negedge clk);
      csr_addr  = a;
      csr_kind  = k;
      csr_wdata = d;
      #1;
      rd  = csr_rdata;
      ill = csr_illegal;
      @(posedge clk);
      #1;
      csr_kind = K_RD;
   endtask

   task automatic rd_view(input logic [11:0] a, output logic [31:0] rd);
      logic ill;
      acc(a, K_RD, 32'h0, rd, ill);
   endtask

   task automatic trap_op(input logic ent, input logic [1:0] p, input logic [11:0] a,
                          input logic [1:0] k, input logic [31:0] d, output logic ill);
      @(negedge clk);
      trap_enter = ent;
      trap_exit  = !ent;
      trap_priv  = p;
      csr_addr   = a;
      csr_kind   = k;
      csr_wdata  = d;
      #1;
      ill = csr_illegal;
      @(posedge clk);
      #1;
      trap_enter = 1'b0;
      trap_exit  = 1'b0;
      csr_kind   = K_RD;
   endtask

   task automatic t_reset;
      logic [31:0] r;
      rd_view(A_ST, r);  chk("R1", "packed after reset", r, 32'h0);
      rd_view(A_MVL, r); chk("R1", "max view after reset", r, 32'd1);
      rd_view(A_VL, r);  chk("R1", "len view after reset", r, 32'd1);
      rd_view(A_SUB, r); chk("R1", "group view after reset", r, 32'd1);
      chk("R1", "outputs after reset",
          {mvl_len, vl_len, 5'(subvl_len), src_offs, dst_offs, 2'(dsv_offs)},
          {7'd1, 7'd1, 5'd1, 6'd0, 6'd0, 2'd0});
   endtask

   task automatic t_len_writes;
      logic [31:0] r;
      logic ill;
      acc(A_MVL, K_REG, 32'd8, r, ill);  chk("R5", "max write returns old", r, 32'd1);
      rd_view(A_MVL, r);                 chk("R2", "max true value", r, 32'd8);
      rd_view(A_ST, r);                  chk("R2", "packed max code", r, pk(7, 0, 0, 0, 0, 0));
      acc(A_VL, K_REG, 32'd5, r, ill);   chk("R5", "len write returns new", r, 32'd5);
      rd_view(A_ST, r);                  chk("R2", "packed len code", r, pk(7, 4, 0, 0, 0, 0));
      acc(A_VL, K_REG, 32'd20, r, ill);  chk("R6", "len clamped return", r, 32'd8);
      chk("R6", "len output clamped", 32'(vl_len), 32'd8);
   endtask

   task automatic t_illegal;
      logic [31:0] r;
      logic ill;
      acc(A_MVL, K_REG, 32'd0, r, ill);  chk("R3", "max zero flagged", 32'(ill), 32'd1);
      acc(A_MVL, K_REG, 32'd33, r, ill); chk("R3", "max 33 flagged", 32'(ill), 32'd1);
      acc(A_VL, K_REG, 32'd0, r, ill);   chk("R3", "len zero flagged", 32'(ill), 32'd1);
      acc(A_VL, K_REG, 32'd33, r, ill);  chk("R3", "len 33 flagged", 32'(ill), 32'd1);
      rd_view(A_ST, r);                  chk("R3", "state kept", r, pk(7, 7, 0, 0, 0, 0));
      acc(A_MVL, K_REG, 32'd32, r, ill); chk("R3", "max 32 accepted", 32'(ill), 32'd0);
      chk("R5", "max 32 returns old", r, 32'd8);
      acc(A_VL, K_REG, 32'd32, r, ill);  chk("R5", "len 32 returns new", r, 32'd32);
   endtask

   task automatic t_imm;
      logic [31:0] r;
      logic ill;
      acc(A_MVL, K_IMM, 32'd15, r, ill); chk("R5", "imm max returns old", r, 32'd32);
      chk("R4", "imm never flagged", 32'(ill), 32'd0);
      rd_view(A_MVL, r);                 chk("R4", "imm max plus one", r, 32'd16);
      chk("R6", "len pulled to max", 32'(vl_len), 32'd16);
      acc(A_VL, K_IMM, 32'hFFFF_FFE3, r, ill); chk("R4", "imm uses low five bits", r, 32'd4);
      acc(A_VL, K_IMM, 32'd9, r, ill);   chk("R4", "imm len returns new", r, 32'd10);
      rd_view(A_VL, r);                  chk("R4", "imm len stored", r, 32'd10);
      acc(A_MVL, K_IMM, 32'd31, r, ill);
      rd_view(A_MVL, r);                 chk("R4", "imm max top", r, 32'd32);
   endtask

   task automatic t_packed;
      logic [31:0] r;
      logic ill;
      acc(A_ST, K_REG, {4'hF, 2'd3, 2'd2, 6'd10, 6'd50, 6'd40, 6'd63}, r, ill);
      chk("R8", "packed write not flagged", 32'(ill), 32'd0);
      rd_view(A_ST, r);
      chk("R8", "packed clamps", r, pk(31, 31, 31, 10, 2, 2));
      chk("R12", "reserved bits zero", 32'(r[31:28]), 32'd0);
      chk("R8", "offset outputs", {26'd0, src_offs}, 32'd31);
      chk("R8", "sub offset output", 32'(dsv_offs), 32'd2);
      acc(A_ST, K_IMM, 32'hFFFF_FFFF, r, ill);
      rd_view(A_ST, r);                  chk("R8", "packed imm write", r, pk(31, 0, 0, 0, 0, 0));
   endtask

   task automatic t_vl_resets;
      logic [31:0] r;
      logic ill;
      acc(A_ST, K_REG, pk(15, 9, 4, 7, 0, 0), r, ill);
      acc(A_VL, K_REG, 32'd6, r, ill);   chk("R9", "len write return", r, 32'd6);
      rd_view(A_ST, r);                  chk("R9", "offsets cleared", r, pk(15, 5, 0, 0, 0, 0));
      chk("R9", "src output zero", 32'(src_offs), 32'd0);
   endtask

   task automatic t_mvl_shrink;
      logic [31:0] r;
      logic ill;
      acc(A_ST, K_REG, pk(15, 5, 5, 3, 0, 0), r, ill);
      acc(A_MVL, K_REG, 32'd3, r, ill);  chk("R5", "shrink returns old", r, 32'd16);
      rd_view(A_ST, r);                  chk("R6", "shrink clamps", r, pk(2, 2, 2, 2, 0, 0));
      chk("R6", "len output", 32'(vl_len), 32'd3);
   endtask

   task automatic t_subvl;
      logic [31:0] r;
      logic ill;
      acc(A_ST, K_REG, pk(7, 3, 0, 0, 3, 3), r, ill);
      acc(A_SUB, K_REG, 32'd0, r, ill);  chk("R7", "group zero flagged", 32'(ill), 32'd1);
      acc(A_SUB, K_REG, 32'd5, r, ill);  chk("R7", "group five flagged", 32'(ill), 32'd1);
      rd_view(A_ST, r);                  chk("R7", "state kept", r, pk(7, 3, 0, 0, 3, 3));
      acc(A_SUB, K_REG, 32'd3, r, ill);  chk("R7", "group returns old", r, 32'd4);
      rd_view(A_SUB, r);                 chk("R7", "group true value", r, 32'd3);
      rd_view(A_ST, r);                  chk("R7", "group code and offset", r, pk(7, 3, 0, 0, 2, 0));
      acc(A_SUB, K_IMM, 32'd1, r, ill);
      chk("R7", "group imm output", 32'(subvl_len), 32'd1);
   endtask

   task automatic t_no_effect;
      logic [31:0] r;
      logic ill;
      acc(A_ST, K_REG, pk(9, 4, 2, 1, 1, 0), r, ill);
      acc(A_MVL, K_RSV, 32'd5, r, ill);  chk("R11", "kind 11 reads", r, 32'd10);
      acc(12'h123, K_REG, 32'd1, r, ill); chk("R11", "other address reads 0", r, 32'd0);
      chk("R11", "other address not flagged", 32'(ill), 32'd0);
      rd_view(A_ST, r);                  chk("R11", "state unchanged", r, pk(9, 4, 2, 1, 1, 0));
   endtask

   task automatic t_trap;
      logic [31:0] r;
      logic ill;
      logic [31:0] x_st;
      logic [31:0] y_st;
      x_st = pk(9, 4, 2, 1, 1, 0);
      y_st = pk(20, 3, 0, 0, 3, 2);
      trap_op(1'b1, 2'd1, A_ST, K_RD, 32'd0, ill);
      rd_view(A_ST, r);                  chk("R10", "enter gives reset shadow", r, 32'd0);
      acc(A_ST, K_REG, y_st, r, ill);
      trap_op(1'b0, 2'd1, A_ST, K_RD, 32'd0, ill);
      rd_view(A_ST, r);                  chk("R10", "exit restores context", r, x_st);
      trap_op(1'b1, 2'd1, A_ST, K_RD, 32'd0, ill);
      rd_view(A_ST, r);                  chk("R10", "handler context kept", r, y_st);
      trap_op(1'b0, 2'd1, A_MVL, K_REG, 32'd0, ill);
      chk("R10", "no flag during trap", 32'(ill), 32'd0);
      rd_view(A_ST, r);                  chk("R10", "write dropped during trap", r, x_st);
      trap_op(1'b1, 2'd2, A_ST, K_RD, 32'd0, ill);
      rd_view(A_ST, r);                  chk("R10", "other level untouched", r, 32'd0);
      trap_op(1'b0, 2'd2, A_ST, K_RD, 32'd0, ill);
      chk("R10", "return to context output", 32'(mvl_len), 32'd10);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      csr_addr   = 12'h0;
      csr_kind   = K_RD;
      csr_wdata  = 32'h0;
      trap_enter = 1'b0;
      trap_exit  = 1'b0;
      trap_priv  = 2'd0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_len_writes();
      t_illegal();
      t_imm();
      t_packed();
      t_vl_resets();
      t_mvl_shrink();
      t_subvl();
      t_no_effect();
      t_trap();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule